// File: doc/BRIEF.md
# Powerdown Sequencing Controller

This block steers a small processor core into and out of a low-power state. A software request halts the core. One cycle later the controller acknowledges that the core is powered down. While the core is down, the controller collects any interrupt events that arrive, so that none is lost. Three things can end the powerdown: a wake pin, the external reset pin, or a software reset request. After a short exit phase the core runs again. A wake-pin exit can keep the core's context, and in that case the collected interrupts are handed to the core in its first running cycle. Every other exit resets the core and throws the collected interrupts away.

The external reset pin counts as an exit only if it was held low long enough for the current clock mode. When the clock keeps running through powerdown, a short pulse is enough. When the clock has been stopped, the low time must cover a fixed base count plus an oscillator settling count. Both counts are parameters, and the oscillator itself is modelled only as that cycle count. A pulse that is too short leaves the core powered down and clears the measurement. A software reset is equivalent to a minimum-length pulse, so it is refused while the clock is stopped.

Top module: `pwrdn_seq_ctrl`

## Requirements
- R1: After `arst_n` is released the controller is in the running state: `core_halt`, `pd_ack` and `core_rst` are all 0, and `irq_out` equals `irq_in`.
- R2: A `pd_req` high while running sets `core_halt` after the next clock edge. `pd_ack` rises one clock edge after `core_halt` rises and stays high while powered down. `pd_req` has no effect while the core is powered down.
- R3: `pd_ack` falls in the first cycle of the exit phase. `core_halt` stays high for all `EXIT_CYC` cycles of that phase, and then the controller returns to running with `core_halt` low.
- R4: A high `pin_wake` while powered down starts the exit phase on the next edge. `core_rst` is high during the exit phase exactly when `ctx_keep` is 0.
- R5: With `clk_stop` = 0, a low pulse on `ext_rst_n` that spans at least `RST_RUN_MIN` clock edges ends powerdown at its rising edge, and `core_rst` is high throughout the exit phase.
- R6: With `clk_stop` = 1, the pulse must span at least `RST_STOP_BASE + SETTLE_CYC` clock edges. A pulse one edge shorter does not end powerdown.
- R7: A pulse shorter than the threshold leaves the controller powered down and clears the pulse measurement at its rising edge, so two short pulses never add up to a valid one.
- R8: A high `sw_rst_req` while powered down starts a resetting exit (`core_rst` high) when `clk_stop` = 0 and is ignored, leaving `pd_ack` high, when `clk_stop` = 1.
- R9: Bit i of `irq_in` that is high in any cycle between the halt and the exit is latched. After a wake-pin exit with `ctx_keep` = 1, it appears on `irq_out` bit i in the first running cycle only, and is then gone.
- R10: On any exit with `core_rst` high (reset pin, software reset, or wake pin with `ctx_keep` = 0), the latched interrupts are discarded, and `irq_out` stays 0 after the return to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| arst_n | input | 1 | Asynchronous active-low reset of the controller itself |
| pd_req | input | 1 | Software powerdown request |
| pin_wake | input | 1 | Wake pin, active high, sampled while powered down |
| ext_rst_n | input | 1 | External reset pin, active low, measured while powered down |
| sw_rst_req | input | 1 | Software reset request (minimum-length reset) |
| clk_stop | input | 1 | 1 = clock stopped during powerdown; selects the long reset threshold |
| ctx_keep | input | 1 | 1 = a wake-pin exit keeps context and releases latched interrupts |
| irq_in | input | IRQ_W | Interrupt event inputs |
| irq_out | output | IRQ_W | Interrupts presented to the core while it runs |
| core_halt | output | 1 | Halts the core |
| pd_ack | output | 1 | Powerdown acknowledge |
| core_rst | output | 1 | Internal reset to the core during a resetting exit |

## Verification
The reset-pin exit is swept pulse length by pulse length across each threshold. In running-clock mode the sweep covers one to eight edges, and in stopped-clock mode it covers a window around the long threshold. This pins down the exact edge where a pulse becomes valid in each mode and shows that the mode bit chooses the threshold. Pairs of short pulses separated by one high cycle show that the measurement is cleared and not accumulated. Interrupt patterns spread over several powered-down cycles are pushed through each kind of exit. This separates context-preserving release from the three resetting exits, and a software reset is tried in both clock modes.

// File: rtl/pwrdn_seq_pkg.sv
package pwrdn_seq_pkg;

   // One-hot controller states
   typedef enum logic [3:0] {
      ST_RUN   = 4'b0001,
      ST_ENTER = 4'b0010,
      ST_PDN   = 4'b0100,
      ST_EXIT  = 4'b1000
   } pd_state_e;

endpackage

// File: rtl/pd_rst_meter.sv
module pd_rst_meter #(
   parameter int RST_RUN_MIN   = 5,
   parameter int RST_STOP_BASE = 1000,
   parameter int SETTLE_CYC    = 2000
) (
   input  logic clk,
   input  logic arst_n,
   input  logic armed,
   input  logic ext_rst_n,
   input  logic clk_stop,
   output logic rst_exit
);
   localparam int STOP_MIN = RST_STOP_BASE + SETTLE_CYC;
   localparam int CW       = $clog2(STOP_MIN + 1);
   localparam logic [CW-1:0] STOP_THR = CW'(STOP_MIN);
   localparam logic [CW-1:0] RUN_THR  = CW'(RST_RUN_MIN);

   initial begin
      assert (RST_RUN_MIN >= 1) else $error("RST_RUN_MIN must be at least 1");
      assert (RST_RUN_MIN <= STOP_MIN) else $error("running threshold exceeds stopped threshold");
   end

   logic [CW-1:0] low_cnt;
   logic          rst_q;
   logic          rise;
   logic [CW-1:0] thr;

   assign thr      = clk_stop ? STOP_THR : RUN_THR;
   assign rise     = ext_rst_n & ~rst_q;
   assign rst_exit = armed & rise & (low_cnt >= thr);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         low_cnt <= '0;
         rst_q   <= 1'b1;
      end else begin
         rst_q <= ext_rst_n;
         if (!armed || rise)
            low_cnt <= '0;
         else if (!ext_rst_n && low_cnt != STOP_THR)
            low_cnt <= low_cnt + 1'b1;
      end
   end

   // R7: the measurement is cleared after every rising edge
   p_clear_on_rise_r7: assert property (@(posedge clk) disable iff (!arst_n)
      (armed && rise) |=> (low_cnt == '0));

   // R5/R6: an accepted pulse was long enough for the mode
   p_exit_long_enough_r6: assert property (@(posedge clk) disable iff (!arst_n)
      rst_exit |-> (clk_stop ? (low_cnt >= STOP_THR) : (low_cnt >= RUN_THR)));

endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
   import pwrdn_seq_pkg::*;
#(
   parameter int EXIT_CYC = 4
) (
   input  logic clk,
   input  logic arst_n,
   input  logic pd_req,
   input  logic pin_wake,
   input  logic sw_rst_req,
   input  logic clk_stop,
   input  logic ctx_keep,
   input  logic rst_exit,
   output logic armed,
   output logic running,
   output logic latch_en,
   output logic discard,
   output logic core_halt,
   output logic pd_ack,
   output logic core_rst
);
   localparam int ECW = (EXIT_CYC > 1) ? $clog2(EXIT_CYC) : 1;
   localparam logic [ECW-1:0] ELAST = ECW'(EXIT_CYC - 1);

   initial begin
      assert (EXIT_CYC >= 1) else $error("EXIT_CYC must be at least 1");
   end

   pd_state_e      state, state_nx;
   logic [ECW-1:0] ecnt;
   logic           full_q;
   logic           go_exit;
   logic           full_nx;
   logic           sw_ok;

   assign sw_ok = sw_rst_req & ~clk_stop;

   always_comb begin
      go_exit = 1'b0;
      full_nx = 1'b0;
      if (rst_exit) begin
         go_exit = 1'b1;
         full_nx = 1'b1;
      end else if (sw_ok) begin
         go_exit = 1'b1;
         full_nx = 1'b1;
      end else if (pin_wake) begin
         go_exit = 1'b1;
         full_nx = ~ctx_keep;
      end
   end

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_RUN:   if (pd_req) state_nx = ST_ENTER;
         ST_ENTER: state_nx = ST_PDN;
         ST_PDN:   if (go_exit) state_nx = ST_EXIT;
         ST_EXIT:  if (ecnt == ELAST) state_nx = ST_RUN;
         default:  state_nx = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state  <= ST_RUN;
         ecnt   <= '0;
         full_q <= 1'b0;
      end else begin
         state <= state_nx;
         if (state == ST_PDN && go_exit) begin
            ecnt   <= '0;
            full_q <= full_nx;
         end else if (state == ST_EXIT) begin
            ecnt <= ecnt + 1'b1;
         end
      end
   end

   assign armed     = (state == ST_PDN);
   assign running   = (state == ST_RUN);
   assign core_halt = ~running;
   assign pd_ack    = (state == ST_PDN);
   assign core_rst  = (state == ST_EXIT) & full_q;
   assign latch_en  = (state == ST_ENTER) | (state == ST_PDN) |
                      ((state == ST_EXIT) & ~full_q);
   assign discard   = armed & go_exit & full_nx;

   p_state_onehot: assert property (@(posedge clk) disable iff (!arst_n)
      $countones(state) == 1);

   // R2: the acknowledge follows an already applied halt
   p_ack_after_halt_r2: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(pd_ack) |-> $past(core_halt));

   // R3: the halt is held while the acknowledge drops
   p_halt_through_exit_r3: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(pd_ack) |-> core_halt);

   // R4: the core reset only appears while the core is halted
   p_rst_only_halted_r4: assert property (@(posedge clk) disable iff (!arst_n)
      core_rst |-> (core_halt && !pd_ack));

   // R8: a software reset with a stopped clock leaves powerdown untouched
   p_sw_refused_r8: assert property (@(posedge clk) disable iff (!arst_n)
      (pd_ack && sw_rst_req && clk_stop && !pin_wake && !rst_exit) |=> pd_ack);

endmodule

// File: rtl/pd_irq_hold.sv
module pd_irq_hold #(
   parameter int IRQ_W = 4
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             latch_en,
   input  logic             running,
   input  logic             discard,
   input  logic [IRQ_W-1:0] irq_in,
   output logic [IRQ_W-1:0] irq_out
);
   initial begin
      assert (IRQ_W >= 1) else $error("IRQ_W must be at least 1");
   end

   logic [IRQ_W-1:0] pend;

   for (genvar i = 0; i < IRQ_W; i++) begin : g_line
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n)
            pend[i] <= 1'b0;
         else if (discard)
            pend[i] <= 1'b0;
         else if (latch_en)
            pend[i] <= pend[i] | irq_in[i];
         else
            pend[i] <= 1'b0;
      end
      assign irq_out[i] = running & (pend[i] | irq_in[i]);

      // R9: an event seen while latching is held unless discarded
      p_latch_r9: assert property (@(posedge clk) disable iff (!arst_n)
         (latch_en && irq_in[i] && !discard) |=> pend[i]);

      // R10: a discard leaves nothing pending
      p_discard_r10: assert property (@(posedge clk) disable iff (!arst_n)
         discard |=> !pend[i]);
   end

endmodule

// File: rtl/pwrdn_seq_ctrl.sv
module pwrdn_seq_ctrl #(
   parameter int IRQ_W         = 4,
   parameter int RST_RUN_MIN   = 5,
   parameter int RST_STOP_BASE = 1000,
   parameter int SETTLE_CYC    = 2000,
   parameter int EXIT_CYC      = 4
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             pd_req,
   input  logic             pin_wake,
   input  logic             ext_rst_n,
   input  logic             sw_rst_req,
   input  logic             clk_stop,
   input  logic             ctx_keep,
   input  logic [IRQ_W-1:0] irq_in,
   output logic [IRQ_W-1:0] irq_out,
   output logic             core_halt,
   output logic             pd_ack,
   output logic             core_rst
);
   logic armed, running, latch_en, discard, rst_exit;

   pd_rst_meter #(
      .RST_RUN_MIN  (RST_RUN_MIN),
      .RST_STOP_BASE(RST_STOP_BASE),
      .SETTLE_CYC   (SETTLE_CYC)
   ) u_meter (
      .clk      (clk),
      .arst_n   (arst_n),
      .armed    (armed),
      .ext_rst_n(ext_rst_n),
      .clk_stop (clk_stop),
      .rst_exit (rst_exit)
   );

   pd_seq_fsm #(
      .EXIT_CYC(EXIT_CYC)
   ) u_fsm (
      .clk       (clk),
      .arst_n    (arst_n),
      .pd_req    (pd_req),
      .pin_wake  (pin_wake),
      .sw_rst_req(sw_rst_req),
      .clk_stop  (clk_stop),
      .ctx_keep  (ctx_keep),
      .rst_exit  (rst_exit),
      .armed     (armed),
      .running   (running),
      .latch_en  (latch_en),
      .discard   (discard),
      .core_halt (core_halt),
      .pd_ack    (pd_ack),
      .core_rst  (core_rst)
   );

   pd_irq_hold #(
      .IRQ_W(IRQ_W)
   ) u_irq (
      .clk     (clk),
      .arst_n  (arst_n),
      .latch_en(latch_en),
      .running (running),
      .discard (discard),
      .irq_in  (irq_in),
      .irq_out (irq_out)
   );

   // R1: a running core is never held in reset or acknowledged as down
   p_run_quiet_r1: assert property (@(posedge clk) disable iff (!arst_n)
      !core_halt |-> (!pd_ack && !core_rst));

endmodule

// File: tb/pwrdn_seq_ctrl_tb.sv
module pwrdn_seq_ctrl_tb;
   localparam int W     = 4;
   localparam int RMIN  = 5;
   localparam int SBASE = 10;
   localparam int SET   = 20;
   localparam int ECYC  = 3;
   localparam int STHR  = SBASE + SET;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic pd_req = 1'b0, pin_wake = 1'b0, ext_rst_n = 1'b1, sw_rst_req = 1'b0;
   logic clk_stop = 1'b0, ctx_keep = 1'b1;
   logic [W-1:0] irq_in = '0;
   logic [W-1:0] irq_out;
   logic core_halt, pd_ack, core_rst;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pwrdn_seq_ctrl #(
      .IRQ_W(W), .RST_RUN_MIN(RMIN), .RST_STOP_BASE(SBASE),
      .SETTLE_CYC(SET), .EXIT_CYC(ECYC)
   ) u_dut (
      .clk(clk), .arst_n(arst_n), .pd_req(pd_req), .pin_wake(pin_wake),
      .ext_rst_n(ext_rst_n), .sw_rst_req(sw_rst_req), .clk_stop(clk_stop),
      .ctx_keep(ctx_keep), .irq_in(irq_in), .irq_out(irq_out),
      .core_halt(core_halt), .pd_ack(pd_ack), .core_rst(core_rst)
   );

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // halt, then acknowledge one edge later
   task automatic go_down();
      pd_req = 1'b1;
      step();
      pd_req = 1'b0;
      chk("R2 halt", core_halt, 1);
      chk("R2 ack late", pd_ack, 0);
      step();
      chk("R2 ack", pd_ack, 1);
   endtask

   // already in the first exit cycle: walk the exit phase
   task automatic ride_exit(int rst_exp);
      for (int k = 1; k <= ECYC; k++) begin
         chk("R3 ack low", pd_ack, 0);
         chk("R3 halt held", core_halt, 1);
         chk("R4 core_rst", core_rst, rst_exp);
         if (k < ECYC) step();
      end
      step();
      chk("R3 running", core_halt, 0);
   endtask

   task automatic wake(int rst_exp);
      pin_wake = 1'b1;
      step();
      pin_wake = 1'b0;
      ride_exit(rst_exp);
   endtask

   task automatic pulse(int len);
      ext_rst_n = 1'b0;
      repeat (len) step();
      ext_rst_n = 1'b1;
      step();
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         report();
      end
   end

   initial begin
      step();
      arst_n = 1'b1;
      irq_in = 4'b0110;
      step();
      chk("R1 halt", core_halt, 0);
      chk("R1 ack", pd_ack, 0);
      chk("R1 core_rst", core_rst, 0);
      chk("R1 irq pass", irq_out, 4'b0110);
      irq_in = '0;

      // R2/R4: basic cycle, pd_req while down ignored, pin exit with context
      go_down();
      pd_req = 1'b1;
      step();
      pd_req = 1'b0;
      chk("R2 req ignored", pd_ack, 1);
      wake(0);

      // R5: running-clock threshold sweep
      clk_stop = 1'b0;
      for (int len = 1; len <= 8; len++) begin
         go_down();
         pulse(len);
         if (len >= RMIN) begin
            chk("R5 exit", pd_ack, 0);
            ride_exit(1);
         end else begin
            chk("R5 stays down", pd_ack, 1);
            wake(0);
         end
      end

      // R6: stopped-clock threshold sweep
      clk_stop = 1'b1;
      for (int len = STHR - 3; len <= STHR + 2; len++) begin
         go_down();
         pulse(len);
         if (len >= STHR) begin
            chk("R6 exit", pd_ack, 0);
            ride_exit(1);
         end else begin
            chk("R6 stays down", pd_ack, 1);
            wake(0);
         end
      end
      go_down();
      pulse(RMIN);
      chk("R6 short pulse refused", pd_ack, 1);
      wake(0);

      // R7: two short pulses do not add up
      clk_stop = 1'b0;
      go_down();
      pulse(RMIN - 1);
      pulse(RMIN - 1);
      chk("R7 running no sum", pd_ack, 1);
      wake(0);
      clk_stop = 1'b1;
      go_down();
      pulse(STHR - 1);
      pulse(STHR - 1);
      chk("R7 stopped no sum", pd_ack, 1);
      wake(0);

      // R8: software reset in both clock modes
      clk_stop = 1'b1;
      go_down();
      sw_rst_req = 1'b1;
      step();
      sw_rst_req = 1'b0;
      chk("R8 sw ignored", pd_ack, 1);
      step();
      chk("R8 sw ignored later", pd_ack, 1);
      clk_stop = 1'b0;
      sw_rst_req = 1'b1;
      step();
      sw_rst_req = 1'b0;
      chk("R8 sw exit", pd_ack, 0);
      ride_exit(1);

      // R9: latched interrupts released once after a context exit
      ctx_keep = 1'b1;
      irq_in = 4'b0001;
      go_down();
      irq_in = 4'b0100;
      step();
      irq_in = 4'b1000;
      step();
      irq_in = '0;
      chk("R9 gated while down", irq_out, 0);
      wake(0);
      chk("R9 released", irq_out, 4'b1101);
      step();
      chk("R9 released once", irq_out, 0);

      // R10: pin exit without context discards
      ctx_keep = 1'b0;
      go_down();
      irq_in = 4'b0011;
      step();
      irq_in = '0;
      wake(1);
      chk("R10 pin full reset", irq_out, 0);

      // R10: reset-pin exit discards even with context bit set
      ctx_keep = 1'b1;
      go_down();
      irq_in = 4'b1010;
      step();
      irq_in = '0;
      pulse(RMIN);
      chk("R10 reset exit", pd_ack, 0);
      ride_exit(1);
      chk("R10 reset discards", irq_out, 0);

      // R10: software reset exit discards
      go_down();
      irq_in = 4'b0101;
      step();
      irq_in = '0;
      sw_rst_req = 1'b1;
      step();
      sw_rst_req = 1'b0;
      ride_exit(1);
      chk("R10 sw discards", irq_out, 0);

      done = 1'b1;
      report();
   end
endmodule